// File: doc/BRIEF.md
# Maskable repeating alarm unit

This block watches a running calendar clock and raises alarms. It holds the settings of several independent alarms (two by default). Each alarm carries six time fields: second, minute, hour, date, month and day of week. Each field has its own compare-enable bit, so an alarm can ignore any field it does not need. Once per 1 Hz tick, the block compares every alarm against the live time. A match sets a sticky status flag for that alarm and can start an active-low interrupt pulse of fixed length.

Reading the status register clears the flags. The surrounding register logic signals that read with a one-cycle strobe at the moment the read's eighth serial clock falls. A single mode bit selects between two behaviours. In one-shot mode an alarm goes quiet after it fires until software clears its flag. In recurring mode it fires on every matching second, so a mask that compares only the seconds field gives one event per minute. Register storage sits outside the block; the alarm settings arrive as plain input vectors.

Top module: `alarm_unit`

## Requirements
- R1: Field f of every time vector lies in bits [f*FIELD_W +: FIELD_W]: f=0 second, 1 minute, 2 hour, 3 date, 4 month, 5 day of week. Alarm a uses the value slice [a*6*FIELD_W +: 6*FIELD_W] and enable bits [a*6 +: 6]. Alarm a matches when each field whose enable bit is 1 equals the live field. Fields whose enable bit is 0 are ignored, so an all-zero mask matches on every tick.
- R2: The comparison is made only in a cycle where `tick_1hz` is 1. A match presented without a tick changes neither the flags nor `irq_n`.
- R3: When an alarm fires, its `alarm_flag` bit is 1 from the next cycle onward, whatever its interrupt enable bit is.
- R4: A `stat_rd` strobe clears all flags in the next cycle, except the flag of an alarm that fires in the same cycle, which is set.
- R5: `irq_n` goes to 0 in the cycle after an alarm fires, provided that alarm's `alm_ien` bit is 1. Alarms whose `alm_ien` bit is 0 never pull `irq_n` low.
- R6: The low pulse on `irq_n` returns to 1 in the cycle after the PULSE_MS-th `tick_ms` strobe that follows the firing. Alarms that fire together make one pulse, and a new firing during a pulse restarts its count.
- R7: With `repeat_mode` = 0 (one-shot), an alarm fires only while its flag is 0. A match while the flag is set gives neither a flag change nor a pulse.
- R8: With `repeat_mode` = 1 (recurring), an alarm fires on every matching tick, even while its flag is already set.
- R9: While `rst_n` is 0, and in the first cycle after it is released, all flags are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe once per second; enables the compare |
| tick_ms | input | 1 | One-cycle strobe once per millisecond; times the pulse |
| stat_rd | input | 1 | One-cycle strobe: status register read completed its eighth clock |
| repeat_mode | input | 1 | 0 one-shot, 1 recurring |
| now_time | input | 6*FIELD_W | Live time fields |
| alm_val | input | NUM_ALARMS*6*FIELD_W | Alarm field values |
| alm_fen | input | NUM_ALARMS*6 | Per-field compare enables |
| alm_ien | input | NUM_ALARMS | Per-alarm interrupt enables |
| alarm_flag | output | NUM_ALARMS | Sticky per-alarm status flags |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
The bench builds the block with two alarms, FIELD_W = 2 and PULSE_MS = 3. With 2-bit fields, every one of the 64 field-enable masks can be swept against a spread of live times for both alarms together. Each alarm's match can be predicted from the field equalities alone. The short pulse lets each vector be flushed in three millisecond strobes, which keeps the exact pulse length, the restart on a new firing and the difference between one-shot and recurring mode cheap to check.

// File: rtl/alarm_unit_pkg.sv
package alarm_unit_pkg;

    // Number of time fields per alarm: sec, min, hour, date, month, weekday.
    localparam int NUM_FIELDS = 6;

    typedef enum logic {
        MODE_ONCE   = 1'b0,
        MODE_REPEAT = 1'b1
    } alarm_mode_e;

endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_unit_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] cfg_val,
    input  logic [NUM_FIELDS-1:0]         cfg_en,
    input  logic [NUM_FIELDS*FIELD_W-1:0] now_time,
    output logic                          hit
);

    logic [NUM_FIELDS-1:0] field_ok;

    // A field passes when it is masked out or equal to the live value.
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign field_ok[f] = !cfg_en[f]
                           || (cfg_val[f*FIELD_W +: FIELD_W] == now_time[f*FIELD_W +: FIELD_W]);
    end

    assign hit = &field_ok;

endmodule

// File: rtl/alarm_irq_pulse.sv
module alarm_irq_pulse #(
    parameter int PULSE_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick_ms,
    output logic irq_n
);

    localparam int CNT_W = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             low;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            // A new firing (re)starts the full pulse width.
            st_d.cnt = CNT_W'(PULSE_TICKS);
        end else if (tick_ms && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.low = (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = ~st_q.low;

endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import alarm_unit_pkg::*;
#(
    parameter int NUM_ALARMS = 2,
    parameter int FIELD_W    = 8,
    parameter int PULSE_MS   = 25
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   tick_1hz,
    input  logic                                   tick_ms,
    input  logic                                   stat_rd,
    input  logic                                   repeat_mode,
    input  logic [NUM_FIELDS*FIELD_W-1:0]          now_time,
    input  logic [NUM_ALARMS*NUM_FIELDS*FIELD_W-1:0] alm_val,
    input  logic [NUM_ALARMS*NUM_FIELDS-1:0]       alm_fen,
    input  logic [NUM_ALARMS-1:0]                  alm_ien,
    output logic [NUM_ALARMS-1:0]                  alarm_flag,
    output logic                                   irq_n
);

    localparam int TIME_W = NUM_FIELDS * FIELD_W;

    typedef struct packed {
        logic [NUM_ALARMS-1:0] flags;
    } unit_state_t;

    unit_state_t           st_d, st_q;
    logic [NUM_ALARMS-1:0] hit;
    logic [NUM_ALARMS-1:0] fire;
    logic                  pulse_req;
    alarm_mode_e           mode_sel;

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        alarm_match #(
            .FIELD_W (FIELD_W)
        ) u_match (
            .cfg_val  (alm_val[a*TIME_W +: TIME_W]),
            .cfg_en   (alm_fen[a*NUM_FIELDS +: NUM_FIELDS]),
            .now_time (now_time),
            .hit      (hit[a])
        );
    end

    assign mode_sel = alarm_mode_e'(repeat_mode);

    always_comb begin
        st_d = st_q;
        fire = '0;
        for (int a = 0; a < NUM_ALARMS; a++) begin
            // One-shot alarms stay disarmed while their flag is pending.
            fire[a] = tick_1hz && hit[a]
                    && ((mode_sel == MODE_REPEAT) || !st_q.flags[a]);
        end
        if (stat_rd) begin
            st_d.flags = '0;
        end
        st_d.flags = st_d.flags | fire;
        pulse_req  = |(fire & alm_ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    alarm_irq_pulse #(
        .PULSE_TICKS (PULSE_MS)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pulse_req),
        .tick_ms (tick_ms),
        .irq_n   (irq_n)
    );

    assign alarm_flag = st_q.flags;

endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk #(
    parameter int NUM_ALARMS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_1hz,
    input logic                  tick_ms,
    input logic                  stat_rd,
    input logic [NUM_ALARMS-1:0] alm_ien,
    input logic [NUM_ALARMS-1:0] alarm_flag,
    input logic                  irq_n
);

    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (|(alarm_flag & ~$past(alarm_flag))) |-> $past(tick_1hz)); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_rd) && !$past(tick_1hz)) |-> (alarm_flag == '0)); // R4

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(tick_1hz) && (|$past(alm_ien)))); // R5

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((alm_ien == '0) && irq_n) |=> irq_n); // R5

    AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !tick_ms) |=> !irq_n); // R6

endmodule

bind alarm_unit alarm_unit_chk #(
    .NUM_ALARMS (NUM_ALARMS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1hz   (tick_1hz),
    .tick_ms    (tick_ms),
    .stat_rd    (stat_rd),
    .alm_ien    (alm_ien),
    .alarm_flag (alarm_flag),
    .irq_n      (irq_n)
);

// File: tb/alarm_unit_test.sv
`timescale 1ns/1ps
module alarm_unit_test;

    localparam int NA  = 2;
    localparam int FW  = 2;
    localparam int NF  = 6;
    localparam int PMS = 3;
    localparam int TW  = NF * FW;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            tick_1hz, tick_ms, stat_rd, repeat_mode;
    logic [TW-1:0]   now_time;
    logic [NA*TW-1:0] alm_val;
    logic [NA*NF-1:0] alm_fen;
    logic [NA-1:0]   alm_ien;
    logic [NA-1:0]   alarm_flag;
    logic            irq_n;

    int n_vec  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    alarm_unit #(
        .NUM_ALARMS (NA),
        .FIELD_W    (FW),
        .PULSE_MS   (PMS)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_1hz    (tick_1hz),
        .tick_ms     (tick_ms),
        .stat_rd     (stat_rd),
        .repeat_mode (repeat_mode),
        .now_time    (now_time),
        .alm_val     (alm_val),
        .alm_fen     (alm_fen),
        .alm_ien     (alm_ien),
        .alarm_flag  (alarm_flag),
        .irq_n       (irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected match from field equality under the enable mask (R1).
    function automatic logic model_hit(input logic [TW-1:0] v, input logic [NF-1:0] en,
                                       input logic [TW-1:0] now);
        for (int f = 0; f < NF; f++)
            if (en[f] && (v[f*FW +: FW] != now[f*FW +: FW])) return 1'b0;
        return 1'b1;
    endfunction

    task automatic sec_tick();
        tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic ms_tick();
        tick_ms = 1'b1; @(negedge clk); tick_ms = 1'b0;
    endtask

    task automatic rd_status();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic flush();
        for (int i = 0; i < PMS; i++) ms_tick();
    endtask

    localparam logic [TW-1:0] VA = 12'b11_10_01_00_11_10;
    localparam logic [TW-1:0] VB = 12'b00_01_10_11_00_01;

    function automatic logic [TW-1:0] live_pat(input int k);
        logic [TW-1:0] t;
        if (k == 0) return VA;
        if (k == 1) return VB;
        for (int f = 0; f < NF; f++) t[f*FW +: FW] = FW'((k * 5 + f * 3) % 4);
        return t;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [NA-1:0] expf;
        rst_n = 1'b0; tick_1hz = 0; tick_ms = 0; stat_rd = 0; repeat_mode = 1'b1;
        now_time = '0; alm_val = {VB, VA}; alm_fen = '0; alm_ien = '1;
        repeat (3) @(negedge clk);
        chk("R9 flags in reset", 32'(alarm_flag), 0);
        chk("R9 irq in reset", 32'(irq_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 flags after reset", 32'(alarm_flag), 0);
        chk("R9 irq after reset", 32'(irq_n), 1);

        // Sweep every enable mask against a set of live times (R1 R3 R5 R8).
        for (int m = 0; m < 64; m++) begin
            for (int k = 0; k < 8; k++) begin
                alm_fen  = {6'(m) ^ 6'h15, 6'(m)};
                now_time = live_pat(k);
                rd_status();
                expf[0] = model_hit(VA, 6'(m), now_time);
                expf[1] = model_hit(VB, 6'(m) ^ 6'h15, now_time);
                sec_tick();
                chk("R1 R3 sweep flags", 32'(alarm_flag), 32'(expf));
                chk("R5 sweep irq", 32'(irq_n), 32'(!(|expf)));
                flush();
                chk("R6 sweep irq released", 32'(irq_n), 1);
            end
        end

        // R2: a match without the 1 Hz tick does nothing.
        alm_fen = '1; now_time = VA; rd_status();
        repeat (3) @(negedge clk);
        chk("R2 no tick flags", 32'(alarm_flag), 0);
        chk("R2 no tick irq", 32'(irq_n), 1);

        // R3 R5: both interrupts masked, flag still set, irq quiet.
        alm_ien = 2'b00; sec_tick();
        chk("R3 masked flag", 32'(alarm_flag), 1);
        chk("R5 masked irq", 32'(irq_n), 1);
        @(negedge clk);
        chk("R5 masked irq later", 32'(irq_n), 1);

        // R5: only alarm0 enabled, only alarm1 matches.
        rd_status(); alm_ien = 2'b01; now_time = VB; sec_tick();
        chk("R3 other alarm flag", 32'(alarm_flag), 2);
        chk("R5 per-alarm enable", 32'(irq_n), 1);

        // R6: both match together -> one pulse of PMS ms ticks.
        rd_status(); alm_ien = 2'b11; alm_fen = '0; sec_tick();
        chk("R6 both flags", 32'(alarm_flag), 3);
        chk("R6 pulse start", 32'(irq_n), 0);
        ms_tick(); ms_tick();
        chk("R6 pulse still low", 32'(irq_n), 0);
        ms_tick();
        chk("R6 pulse end", 32'(irq_n), 1);

        // R6: a firing during a pulse restarts the count; R8 re-fires with flags set.
        sec_tick(); ms_tick();
        sec_tick();
        chk("R8 refire irq", 32'(irq_n), 0);
        ms_tick(); ms_tick();
        chk("R6 restart still low", 32'(irq_n), 0);
        ms_tick();
        chk("R6 restart end", 32'(irq_n), 1);

        // R4: read with simultaneous firing of alarm0 only.
        alm_fen = {6'h3F, 6'h3F}; now_time = VA;
        stat_rd = 1'b1; tick_1hz = 1'b1; @(negedge clk); stat_rd = 1'b0; tick_1hz = 1'b0;
        chk("R4 set wins over read", 32'(alarm_flag), 1);
        flush();
        rd_status();
        chk("R4 read clears", 32'(alarm_flag), 0);

        // R7: one-shot mode.
        repeat_mode = 1'b0; sec_tick();
        chk("R7 first fire flag", 32'(alarm_flag), 1);
        chk("R7 first fire irq", 32'(irq_n), 0);
        flush();
        sec_tick();
        chk("R7 disarmed irq", 32'(irq_n), 1);
        chk("R7 disarmed flag", 32'(alarm_flag), 1);
        rd_status();
        chk("R7 cleared", 32'(alarm_flag), 0);
        sec_tick();
        chk("R7 rearmed irq", 32'(irq_n), 0);
        chk("R7 rearmed flag", 32'(alarm_flag), 1);
        flush();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule